// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block turns single requests from an internal port into strobe sequences for an external asynchronous static memory: SRAM, pseudo-static RAM or NOR flash. A request carries an address, write data, byte enables and a read/write flag. The controller accepts it when `req_ready` is high. It drives chip-enable, output-enable, write-enable, an address-valid pulse and byte-lane strobes. When the access ends it returns a one-cycle `req_done`, and on reads it also returns the captured data. Every output comes straight from a flop clocked by `clk`, and that clock never leaves the block.

Each access runs through up to three timed phases: address setup, address hold and data. Their lengths come from configuration fields and are counted in `clk` cycles. The set of phases used, and the shapes of the strobes, depend on a timing mode. With the extended flag clear, the memory type picks the mode. With the flag set, reads and writes each take their own mode from four extended choices. The finite-state machine has the states IDLE, SETUP, HOLD, DATA and DONE. Its transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→HOLD or SETUP→DATA when the setup count expires. HOLD is used only in modes that have a hold phase.
- HOLD→DATA when the hold count expires.
- DATA→DONE when the data count expires.
- DONE→IDLE unconditionally.

Top module: `asm_ctrl`

## Requirements
- R1: A synchronous reset, asserted in any state, returns the block to IDLE on the next edge. The block then shows all strobes high (`mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_adv_n`, every `mem_bl_n` bit), `mem_dq_oe` low, `req_done` low and `req_ready` high.
- R2: With `cfg_ext`=0, memory type codes 00 (SRAM), 01 (PSRAM) and 11 use mode 1, and type code 10 (NOR) uses mode 2.
- R3: With `cfg_ext`=1, a read uses the mode in `cfg_rd_mode` and a write uses the mode in `cfg_wr_mode`. The encoding is 0=A, 1=B, 2=C, 3=D.
- R4: Each mode has three features, given as (address-valid pulse, hold phase, output-enable over the whole access):
  - mode 1 = (no, no, yes)
  - mode 2 = (yes, yes, no)
  - A = (no, no, no)
  - B = (yes, no, no)
  - C = (yes, yes, yes)
  - D = (no, yes, no)
- R5: The phase lengths are:
  - setup S = `cfg_addset`, with 0 taken as 1
  - hold H = `cfg_addhld`, with 0 taken as 1, but only in modes that have a hold phase; otherwise H = 0
  - data D = `cfg_datast`, with 0 taken as 1

  `mem_ce_n` is low for exactly S+H+D consecutive cycles, starting in the cycle after acceptance.
- R6: On reads, `mem_oe_n` is low in the last D cycles, or in all S+H+D cycles in modes with the whole-access output-enable feature. On writes it stays high. On writes, `mem_we_n` is low exactly in the last D cycles. The two strobes are never low together.
- R7: `mem_adv_n` is low exactly in the first S cycles of an access in modes that have the address-valid pulse, and high otherwise.
- R8: While `mem_ce_n` is low, `mem_bl_n` equals the inverted `req_be` on writes and all zeros on reads. Outside an access it is all ones.
- R9: During a write access, `mem_dq_oe` is high and `mem_dq_o` equals the write data for all S+H+D cycles. At all other times `mem_dq_oe` is low. `mem_addr` holds the request address throughout the access.
- R10: Read data is sampled from `mem_dq_i` on the edge that ends the last data cycle, while `mem_oe_n` is still low. It appears on `req_rdata` with `req_done`. It stays unchanged through later writes until the next read completes.
- R11: `req_done` is high for exactly one cycle, the cycle after the last data cycle. `req_ready` is high only in IDLE. At least one cycle with `mem_ce_n` high separates back-to-back accesses.
- R12: A request is accepted on an edge where `req_valid` and `req_ready` are both high. The configuration inputs are sampled on that edge only. Changing them during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, internal only |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mtype | input | 2 | Memory type: 00 SRAM, 01 PSRAM, 10 NOR, 11 treated as SRAM |
| cfg_ext | input | 1 | Extended timing enable |
| cfg_rd_mode | input | 2 | Extended mode for reads (0=A..3=D) |
| cfg_wr_mode | input | 2 | Extended mode for writes (0=A..3=D) |
| cfg_addset | input | SETW (4) | Address setup cycles |
| cfg_addhld | input | HLDW (4) | Address hold cycles |
| cfg_datast | input | DATW (8) | Data phase cycles |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (20) | Request address |
| req_wdata | input | DW (16) | Write data |
| req_be | input | DW/8 (2) | Byte enables, active high |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW (16) | Captured read data |
| mem_addr | output | AW (20) | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid pulse, active low |
| mem_bl_n | output | DW/8 (2) | Byte-lane strobes, active low |
| mem_dq_o | output | DW (16) | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW (16) | Data returned by memory |

## Verification
Two events share one clock edge: the capture of read data and the release of `mem_oe_n`. The memory model in the bench returns a value derived from the address only while `mem_oe_n` is low. Once the strobe is high, it drives the bitwise inverse of that value. A capture that is even one edge late therefore returns the wrong data. Data phases of one cycle, and modes whose output-enable spans the whole access, push this coincidence to its tightest case. The check compares `req_rdata` with the value derived from the address in the `req_done` cycle. The edge of acceptance also coincides with a change in configuration. The bench scrambles every configuration input in the first access cycle, and the strobe shapes must still match the configuration that was present on the acceptance edge.

// File: rtl/asm_pkg.sv
package asm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_DATA,
        ST_DONE
    } asm_state_e;

    typedef enum logic [2:0] {
        TM_1,
        TM_2,
        TM_A,
        TM_B,
        TM_C,
        TM_D
    } asm_tmode_e;

    typedef struct packed {
        logic adv;      // address-valid pulse during setup
        logic hold;     // address-hold phase present
        logic oe_full;  // output enable spans the whole access
    } asm_feat_t;

    function automatic asm_feat_t feat_of(input asm_tmode_e m);
        asm_feat_t f;
        case (m)
            TM_1:    f = '{adv: 1'b0, hold: 1'b0, oe_full: 1'b1};
            TM_2:    f = '{adv: 1'b1, hold: 1'b1, oe_full: 1'b0};
            TM_A:    f = '{adv: 1'b0, hold: 1'b0, oe_full: 1'b0};
            TM_B:    f = '{adv: 1'b1, hold: 1'b0, oe_full: 1'b0};
            TM_C:    f = '{adv: 1'b1, hold: 1'b1, oe_full: 1'b1};
            default: f = '{adv: 1'b0, hold: 1'b1, oe_full: 1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/asm_mode_sel.sv
module asm_mode_sel
    import asm_pkg::*;
(
    input  logic [1:0] mtype,
    input  logic       ext,
    input  logic [1:0] rd_code,
    input  logic [1:0] wr_code,
    input  logic       is_write,
    output asm_feat_t  feat
);

    localparam logic [1:0] MT_NOR = 2'b10;

    asm_tmode_e mode;
    logic [1:0] code;

    always_comb begin
        code = is_write ? wr_code : rd_code;
        if (!ext) begin
            mode = (mtype == MT_NOR) ? TM_2 : TM_1;
        end else begin
            case (code)
                2'd0:    mode = TM_A;
                2'd1:    mode = TM_B;
                2'd2:    mode = TM_C;
                default: mode = TM_D;
            endcase
        end
        feat = feat_of(mode);
    end

endmodule

// File: rtl/asm_phase_timer.sv
module asm_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // R5: the phase counter steps down by exactly one per cycle
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == TW'($past(cnt_q) - 1'b1)));

    // R5: the counter stays at zero until the next phase is loaded
    p_cnt_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/asm_strobe_gen.sv
module asm_strobe_gen
    import asm_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst,
    input  asm_state_e     nxt,
    input  logic           wr,
    input  asm_feat_t      feat,
    input  logic [BEW-1:0] be,
    input  logic           load,
    input  logic [AW-1:0]  addr_in,
    input  logic [DW-1:0]  wdata_in,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_ce_n,
    output logic           mem_oe_n,
    output logic           mem_we_n,
    output logic           mem_adv_n,
    output logic [BEW-1:0] mem_bl_n,
    output logic [DW-1:0]  mem_dq_o,
    output logic           mem_dq_oe,
    output logic           done
);

    logic active;
    logic in_data;
    logic in_setup;

    always_comb begin
        active   = (nxt == ST_SETUP) || (nxt == ST_HOLD) || (nxt == ST_DATA);
        in_data  = (nxt == ST_DATA);
        in_setup = (nxt == ST_SETUP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_adv_n <= 1'b1;
            mem_bl_n  <= '1;
            mem_dq_oe <= 1'b0;
            done      <= 1'b0;
            mem_addr  <= '0;
            mem_dq_o  <= '0;
        end else begin
            mem_ce_n  <= !active;
            mem_oe_n  <= !(!wr && (in_data || (feat.oe_full && active)));
            mem_we_n  <= !(wr && in_data);
            mem_adv_n <= !(feat.adv && in_setup);
            mem_bl_n  <= active ? (wr ? ~be : '0) : '1;
            mem_dq_oe <= wr && active;
            done      <= (nxt == ST_DONE);
            if (load) begin
                mem_addr <= addr_in;
                mem_dq_o <= wdata_in;
            end
        end
    end

    // R8: reads enable every byte lane
    p_bl_read_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_bl_n == '0));

    // R8: byte lanes are idle whenever the chip is deselected
    p_bl_idle_r8: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_bl_n == '1));

    // R6: the two direction strobes never overlap
    p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

endmodule

// File: rtl/asm_ctrl.sv
module asm_ctrl
    import asm_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int SETW = 4,
    parameter int HLDW = 4,
    parameter int DATW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mtype,
    input  logic              cfg_ext,
    input  logic [1:0]        cfg_rd_mode,
    input  logic [1:0]        cfg_wr_mode,
    input  logic [SETW-1:0]   cfg_addset,
    input  logic [HLDW-1:0]   cfg_addhld,
    input  logic [DATW-1:0]   cfg_datast,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_be,
    output logic              req_ready,
    output logic              req_done,
    output logic [DW-1:0]     req_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic [DW/8-1:0]   mem_bl_n,
    output logic [DW-1:0]     mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DW-1:0]     mem_dq_i
);

    localparam int BEW = DW / 8;
    localparam int SH_MAX = (SETW > HLDW) ? SETW : HLDW;
    localparam int TW = (DATW > SH_MAX) ? DATW : SH_MAX;

    function automatic logic [TW-1:0] to_load(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    asm_state_e      state_q, state_nxt;
    asm_feat_t       feat_in, feat_q, feat_nxt;
    logic            wr_q, wr_nxt;
    logic [BEW-1:0]  be_q, be_nxt;
    logic [TW-1:0]   hld_ld_q, dat_ld_q;
    logic [TW-1:0]   t_load_val;
    logic            t_load, t_last;
    logic            accept;
    logic [DW-1:0]   rdata_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign req_rdata = rdata_q;

    asm_mode_sel u_msel (
        .mtype    (cfg_mtype),
        .ext      (cfg_ext),
        .rd_code  (cfg_rd_mode),
        .wr_code  (cfg_wr_mode),
        .is_write (req_write),
        .feat     (feat_in)
    );

    // next-state decode
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_nxt = ST_SETUP;
            ST_SETUP: if (t_last) state_nxt = feat_q.hold ? ST_HOLD : ST_DATA;
            ST_HOLD:  if (t_last) state_nxt = ST_DATA;
            ST_DATA:  if (t_last) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nxt;
    end

    // transaction attributes latched on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            feat_q   <= '0;
            be_q     <= '0;
            hld_ld_q <= '0;
            dat_ld_q <= '0;
        end else if (accept) begin
            wr_q     <= req_write;
            feat_q   <= feat_in;
            be_q     <= req_be;
            hld_ld_q <= to_load(TW'(cfg_addhld));
            dat_ld_q <= to_load(TW'(cfg_datast));
        end
    end

    always_comb begin
        wr_nxt   = accept ? req_write : wr_q;
        feat_nxt = accept ? feat_in   : feat_q;
        be_nxt   = accept ? req_be    : be_q;
        t_load   = (state_nxt != state_q) &&
                   (state_nxt == ST_SETUP || state_nxt == ST_HOLD || state_nxt == ST_DATA);
        unique case (state_nxt)
            ST_SETUP: t_load_val = to_load(TW'(cfg_addset));
            ST_HOLD:  t_load_val = hld_ld_q;
            default:  t_load_val = dat_ld_q;
        endcase
    end

    asm_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_load_val),
        .last     (t_last)
    );

    // read capture on the edge that closes the data phase
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (state_q == ST_DATA && t_last && !wr_q) begin
            rdata_q <= mem_dq_i;
        end
    end

    asm_strobe_gen #(.AW(AW), .DW(DW), .BEW(BEW)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .nxt       (state_nxt),
        .wr        (wr_nxt),
        .feat      (feat_nxt),
        .be        (be_nxt),
        .load      (accept),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_adv_n (mem_adv_n),
        .mem_bl_n  (mem_bl_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .done      (req_done)
    );

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R11: the cycle after completion is idle and ready
    p_gap_r11: assert property (@(posedge clk) disable iff (rst)
        req_done |=> (mem_ce_n && req_ready));

    // R10: output enable is only released together with completion
    p_oe_release_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> req_done);

    // R9: the data bus is driven only inside a selected write access
    p_bus_owned_r9: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

    // R7: the address-valid pulse sits inside the access, away from write enable
    p_adv_inside_r7: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> (!mem_ce_n && mem_we_n));

    // R11: no new acceptance while an access is in flight
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready);

endmodule

// File: tb/asm_ctrl_test.sv
module asm_ctrl_test;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int BEW = DW / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      cfg_mtype = 2'b00;
    logic            cfg_ext = 1'b0;
    logic [1:0]      cfg_rd_mode = 2'd0;
    logic [1:0]      cfg_wr_mode = 2'd0;
    logic [3:0]      cfg_addset = 4'd1;
    logic [3:0]      cfg_addhld = 4'd1;
    logic [7:0]      cfg_datast = 8'd1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic [BEW-1:0]  req_be = '0;
    logic            req_ready, req_done;
    logic [DW-1:0]   req_rdata;
    logic [AW-1:0]   mem_addr;
    logic            mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
    logic [BEW-1:0]  mem_bl_n;
    logic [DW-1:0]   mem_dq_o, mem_dq_i;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    asm_ctrl uut (
        .clk(clk), .rst(rst),
        .cfg_mtype(cfg_mtype), .cfg_ext(cfg_ext),
        .cfg_rd_mode(cfg_rd_mode), .cfg_wr_mode(cfg_wr_mode),
        .cfg_addset(cfg_addset), .cfg_addhld(cfg_addhld), .cfg_datast(cfg_datast),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .req_done(req_done), .req_rdata(req_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_bl_n(mem_bl_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [DW-1:0] mdl(input logic [AW-1:0] a);
        return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]} ^ 16'hC3A5;
    endfunction

    // memory model: valid data only while output enable is low
    always_comb mem_dq_i = mem_oe_n ? ~mdl(mem_addr) : mdl(mem_addr);

    // expected features {adv, hold, oe_full} from mode index 0=M1 1=M2 2=A 3=B 4=C 5=D
    function automatic logic [2:0] exp_feat(input int idx);
        case (idx)
            0: return 3'b001;
            1: return 3'b110;
            2: return 3'b000;
            3: return 3'b100;
            4: return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    function automatic int exp_mode(input logic [1:0] mt, input logic ext,
                                    input logic [1:0] rdm, input logic [1:0] wrm,
                                    input logic wr);
        if (!ext) return (mt == 2'b10) ? 1 : 0;
        return 2 + int'(wr ? wrm : rdm);
    endfunction

    function automatic int min1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_adv_n && (mem_bl_n == '1) && !mem_dq_oe,
            tag, {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe}, 32'h1E);
    endtask

    task automatic run_txn(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [BEW-1:0] be, input logic [1:0] mt, input logic ext,
                           input logic [1:0] rdm, input logic [1:0] wrm,
                           input logic [3:0] s, input logic [3:0] h, input logic [7:0] d);
        int idx, sl, hl, dl, tot;
        logic [2:0] f;
        logic [4:0] got, exp;
        string rt;
        idx = exp_mode(mt, ext, rdm, wrm, wr);
        f   = exp_feat(idx);
        sl  = min1(int'(s));
        hl  = f[1] ? min1(int'(h)) : 0;
        dl  = min1(int'(d));
        tot = sl + hl + dl;
        rt  = ext ? "R3" : "R2";
        @(negedge clk);
        chk(req_ready, "R11 ready before request", {31'd0, req_ready}, 32'd1);
        cfg_mtype = mt; cfg_ext = ext; cfg_rd_mode = rdm; cfg_wr_mode = wrm;
        cfg_addset = s; cfg_addhld = h; cfg_datast = d;
        req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R12: scramble configuration and request inputs after acceptance
        cfg_mtype = 2'($urandom); cfg_ext = 1'($urandom);
        cfg_rd_mode = 2'($urandom); cfg_wr_mode = 2'($urandom);
        cfg_addset = 4'($urandom); cfg_addhld = 4'($urandom); cfg_datast = 8'($urandom);
        req_write = ~wr; req_addr = ~a; req_wdata = ~wd; req_be = ~be;
        for (int k = 0; k < tot; k++) begin
            exp[4] = 1'b0;
            exp[3] = !(!wr && (k >= sl + hl || f[0]));
            exp[2] = !(wr && k >= sl + hl);
            exp[1] = !(f[2] && k < sl);
            exp[0] = wr;
            got = {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe};
            chk(got == exp, $sformatf("%s R4 R5 R6 R7 R12 strobes k=%0d mode=%0d", rt, k, idx),
                {27'd0, got}, {27'd0, exp});
            chk(mem_bl_n == (wr ? ~be : '0), $sformatf("R8 byte lanes k=%0d", k),
                {30'd0, mem_bl_n}, {30'd0, (wr ? ~be : 2'b00)});
            chk(mem_addr == a && (!wr || mem_dq_o == wd), $sformatf("R9 addr/data k=%0d", k),
                {mem_addr[15:0], mem_dq_o}, {a[15:0], wd});
            chk(!req_ready && !req_done, $sformatf("R11 busy k=%0d", k),
                {30'd0, req_ready, req_done}, 32'd0);
            @(negedge clk);
        end
        chk(req_done, "R11 done after last data cycle", {31'd0, req_done}, 32'd1);
        check_idle("R5 R11 strobes released at done");
        if (!wr) last_rd = mdl(a);
        chk(req_rdata == last_rd, wr ? "R10 rdata held across write" : "R10 read capture",
            {16'd0, req_rdata}, {16'd0, last_rd});
        @(negedge clk);
        chk(!req_done && req_ready && mem_ce_n, "R11 single done and idle gap",
            {29'd0, req_done, req_ready, mem_ce_n}, 32'd3);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 reset strobes");
        chk(req_ready && !req_done, "R1 reset handshake", {30'd0, req_ready, req_done}, 32'd2);
        rst = 1'b0;

        // directed: default modes by memory type
        for (int mt = 0; mt < 4; mt++) begin
            run_txn(1'b0, 20'h1_2345 + 20'(mt), 16'h0, 2'b11, 2'(mt), 1'b0, 2'd0, 2'd0, 4'd2, 4'd3, 8'd2);
            run_txn(1'b1, 20'hA_0000 + 20'(mt), 16'hBEEF, 2'b01, 2'(mt), 1'b0, 2'd0, 2'd0, 4'd1, 4'd2, 8'd3);
        end
        // directed: every extended mode, zero fields, independent read/write modes
        for (int m = 0; m < 4; m++) begin
            run_txn(1'b0, 20'h0_0F00 + 20'(m), 16'h0, 2'b00, 2'b10, 1'b1, 2'(m), 2'(3 - m), 4'd0, 4'd0, 8'd0);
            run_txn(1'b1, 20'h0_0E00 + 20'(m), 16'h1234, 2'b10, 2'b10, 1'b1, 2'(m), 2'(3 - m), 4'd0, 4'd0, 8'd0);
        end
        // directed: maximum setup/hold, long data phase
        run_txn(1'b0, 20'hF_FFFF, 16'h0, 2'b11, 2'b10, 1'b0, 2'd0, 2'd0, 4'd15, 4'd15, 8'd255);

        // directed: reset in the middle of an access
        @(negedge clk);
        cfg_ext = 1'b0; cfg_mtype = 2'b10; cfg_addset = 4'd5; cfg_addhld = 4'd5; cfg_datast = 8'd9;
        req_write = 1'b1; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 reset mid-access");
        chk(req_ready && !req_done, "R1 reset mid-access handshake",
            {30'd0, req_ready, req_done}, 32'd2);
        rst = 1'b0;

        // constrained random
        for (int i = 0; i < 400; i++) begin
            run_txn(1'($urandom), 20'($urandom), 16'($urandom), 2'($urandom),
                    2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                    4'($urandom), 4'($urandom), 8'($urandom_range(0, 20)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule